// File: doc/BRIEF.md
# Breakpoint Opcode Resolver

This block sits between the instruction decoder and the bus interface unit of a processor core. Every opcode that reaches execution is offered to it with a valid strobe. An ordinary opcode passes straight through on the next cycle. An opcode in the breakpoint group (0x4848 to 0x484F) is held back. The block then runs a read cycle in the processor's special address space, and the address of that read carries the breakpoint number.

The block resolves the breakpoint by watching how that read ends. A data acknowledge means a debugger or emulator has supplied a replacement word. That word goes out as the opcode to execute, flagged as a substitution. A bus error means nobody claimed the breakpoint, so the block raises an illegal-instruction exception request. Detection relies only on the opcode value and never on vector fetch addresses, because the vector table base can be moved.

The block resolves one breakpoint at a time. While it waits for a bus cycle it reports busy, so the decoder can stall.

Top module: `bkpt_resolver`

## Requirements
- R1: After reset, the block drives `bus_req`, `out_valid`, `exc_illegal` and `busy` low and `bus_fc` to 3'b000.
- R2: When the block is idle and an opcode outside 0x4848–0x484F is strobed in, `out_valid` is high on the next cycle for exactly one cycle. In that cycle `out_opcode` equals the input opcode, `out_subst` is 0 and no bus request starts.
- R3: When the block is idle and an opcode inside 0x4848–0x484F is strobed in, `bus_req` rises on the next cycle. `bus_fc` is 3'b111 and `bus_addr` is the opcode's low three bits placed at address bits 4:2, with every other address bit 0 (so bits 19:16 are 0). While no request is active, `bus_fc` is 3'b000.
- R4: Once raised, `bus_req` stays high with `bus_addr` and `bus_fc` unchanged until a cycle in which `bus_ack` or `bus_err` is sampled high.
- R5: If `bus_ack` alone ends the request, on the next cycle `bus_req` is low, `out_valid` and `out_subst` are high, and `out_opcode` equals the `bus_rdata` sampled with the acknowledge.
- R6: If `bus_err` ends the request, on the next cycle `bus_req` is low, `exc_illegal` is high for one cycle and `out_valid` stays low.
- R7: If `bus_ack` and `bus_err` are both high in the ending cycle, the bus error outcome of R6 applies.
- R8: `busy` is high from the cycle after a breakpoint is accepted until the request ends. An opcode strobed in while busy is dropped: it produces no `out_valid` and does not change the active request.
- R9: `bus_ack` or `bus_err` arriving while no request is active has no effect on any output.
- R10: `out_valid` and `exc_illegal` are never high in the same cycle, and each is a one-cycle pulse per opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Opcode strobe from the decoder |
| in_opcode | input | 16 | Opcode reaching execution |
| busy | output | 1 | Breakpoint resolution in progress; opcodes are dropped |
| bus_req | output | 1 | Read request to the bus interface |
| bus_addr | output | ADDR_W | Read address (breakpoint number at bits 4:2) |
| bus_fc | output | 3 | Function code, 3'b111 during the request |
| bus_ack | input | 1 | Data acknowledge termination |
| bus_err | input | 1 | Bus error termination |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |
| out_valid | output | 1 | Opcode to execute is valid |
| out_opcode | output | 16 | Pass-through or replacement opcode |
| out_subst | output | 1 | `out_opcode` is a replacement word from the bus |
| exc_illegal | output | 1 | Illegal-instruction exception request pulse |

## Verification
The assertions assume that the bus interface ends each request with a single termination cycle. They also assume that the decoder presents no opcode during the two cycles in which the internal reset is still held after `rst_n` rises. The stimulus meets both conditions. It raises `bus_ack`/`bus_err` for exactly one cycle per request, or deliberately while idle for the R9 case. It strobes opcodes only after the reset settle time. The vector table covers every breakpoint number boundary, the values just outside the range, varied wait lengths and simultaneous terminations.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int OP_W = 16;
  localparam int NUM_W = 3;
  localparam logic [OP_W-1:0] BKPT_FIRST = 16'h4848;
  localparam logic [2:0] FC_CPU = 3'b111;
  localparam logic [2:0] FC_NONE = 3'b000;
  localparam int NUM_LSB = 2;
  localparam int SPACE_LSB = 16;
  localparam int SPACE_W = 4;
  localparam logic [SPACE_W-1:0] SPACE_BKPT = 4'h0;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } bkpt_state_e;
endpackage

// File: rtl/bkpt_rst_sync.sv
module bkpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bkpt_decode.sv
module bkpt_decode
  import bkpt_pkg::*;
(
  input  logic [OP_W-1:0]  opcode,
  output logic             hit,
  output logic [NUM_W-1:0] num
);
  localparam int TAG_W = OP_W - NUM_W;
  localparam logic [TAG_W-1:0] TAG = BKPT_FIRST[OP_W-1:NUM_W];

  assign hit = (opcode[OP_W-1:NUM_W] == TAG);
  assign num = opcode[NUM_W-1:0];
endmodule

// File: rtl/bkpt_addr_gen.sv
module bkpt_addr_gen
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              active,
  input  logic [NUM_W-1:0]  num,
  output logic [ADDR_W-1:0] addr,
  output logic [2:0]        fc
);
  localparam int SPACE_HI = SPACE_LSB + SPACE_W - 1;

  always_comb begin
    addr = '0;
    fc   = FC_NONE;
    if (active) begin
      addr[NUM_LSB +: NUM_W] = num;
      if (ADDR_W > SPACE_HI) addr[SPACE_LSB +: SPACE_W] = SPACE_BKPT;
      fc = FC_CPU;
    end
  end
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
  import bkpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_opcode,
  input  logic             hit,
  input  logic [NUM_W-1:0] num,
  input  logic             bus_ack,
  input  logic             bus_err,
  input  logic [OP_W-1:0]  bus_rdata,
  output logic             bus_active,
  output logic [NUM_W-1:0] num_q,
  output logic             out_valid,
  output logic [OP_W-1:0]  out_opcode,
  output logic             out_subst,
  output logic             exc_illegal
);
  bkpt_state_e state_q, state_d;
  logic            accept, term;
  logic            num_en, op_en;
  logic            valid_d, subst_d, exc_d;
  logic [OP_W-1:0] op_d;

  always_comb begin
    accept  = in_valid && (state_q == ST_IDLE);
    term    = (state_q == ST_BUS) && (bus_ack || bus_err);
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept && hit) state_d = ST_BUS;
      ST_BUS:  if (term)          state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    num_en  = accept && hit;
    valid_d = (accept && !hit) || (term && !bus_err);
    subst_d = term && !bus_err;
    exc_d   = term && bus_err;
    op_en   = valid_d;
    op_d    = accept ? in_opcode : bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      num_q       <= '0;
      out_valid   <= 1'b0;
      out_subst   <= 1'b0;
      exc_illegal <= 1'b0;
      out_opcode  <= '0;
    end else begin
      state_q     <= state_d;
      out_valid   <= valid_d;
      out_subst   <= subst_d;
      exc_illegal <= exc_d;
      if (num_en) num_q      <= num;
      if (op_en)  out_opcode <= op_d;
    end
  end

  assign bus_active = (state_q == ST_BUS);
endmodule

// File: rtl/bkpt_resolver.sv
module bkpt_resolver
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       in_opcode,
  output logic              busy,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_fc,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [15:0]       bus_rdata,
  output logic              out_valid,
  output logic [15:0]       out_opcode,
  output logic              out_subst,
  output logic              exc_illegal
);
  logic             rst_n_int;
  logic             hit;
  logic [NUM_W-1:0] num, num_q;
  logic             active;

  bkpt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  bkpt_decode u_dec (
    .opcode(in_opcode), .hit(hit), .num(num)
  );

  bkpt_seq u_seq (
    .clk(clk), .rst_n(rst_n_int),
    .in_valid(in_valid), .in_opcode(in_opcode),
    .hit(hit), .num(num),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .bus_active(active), .num_q(num_q),
    .out_valid(out_valid), .out_opcode(out_opcode),
    .out_subst(out_subst), .exc_illegal(exc_illegal)
  );

  bkpt_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .active(active), .num(num_q), .addr(bus_addr), .fc(bus_fc)
  );

  assign bus_req = active;
  assign busy    = active;
endmodule

// File: rtl/bkpt_resolver_chk.sv
module bkpt_resolver_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [15:0]       in_opcode,
  input logic              busy,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_fc,
  input logic              bus_ack,
  input logic              bus_err,
  input logic [15:0]       bus_rdata,
  input logic              out_valid,
  input logic [15:0]       out_opcode,
  input logic              out_subst,
  input logic              exc_illegal
);
  localparam logic [ADDR_W-1:0] NUM_FIELD = ADDR_W'(3'b111) << 2;
  logic is_bp;
  assign is_bp = (in_opcode >= 16'h4848) && (in_opcode <= 16'h484F);

  p_addr_fmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_fc == 3'b111) && ((bus_addr & ~NUM_FIELD) == '0));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && is_bp) |=> bus_req && (bus_addr[4:2] == $past(in_opcode[2:0])));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err) |=> bus_req && $stable(bus_addr) && $stable(bus_fc));

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && !is_bp) |=> out_valid && !out_subst && !bus_req
      && (out_opcode == $past(in_opcode)));

  p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_err) |=> !bus_req && out_valid && out_subst
      && (out_opcode == $past(bus_rdata)));

  p_err_r6_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_err) |=> !bus_req && exc_illegal && !out_valid);

  p_idle_fc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (bus_fc == 3'b000));

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && exc_illegal));

  p_exc_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_illegal |=> !exc_illegal);
endmodule

bind bkpt_resolver bkpt_resolver_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
  .busy(busy), .bus_req(bus_req), .bus_addr(bus_addr), .bus_fc(bus_fc),
  .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
  .out_valid(out_valid), .out_opcode(out_opcode), .out_subst(out_subst),
  .exc_illegal(exc_illegal)
);

// File: tb/bkpt_resolver_tb.sv
module bkpt_resolver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int NVEC = 10;

  // {opcode, rdata, wait cycles, term(bit0 ack, bit1 err), pad}
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h4E71, 16'h0000, 4'd0, 2'd0, 2'd0},
    {16'h4848, 16'h4E75, 4'd0, 2'd1, 2'd0},
    {16'h484F, 16'h1111, 4'd3, 2'd1, 2'd0},
    {16'h484B, 16'h0000, 4'd2, 2'd2, 2'd0},
    {16'h4847, 16'h0000, 4'd0, 2'd0, 2'd0},
    {16'h4850, 16'h0000, 4'd0, 2'd0, 2'd0},
    {16'h484C, 16'h2222, 4'd1, 2'd3, 2'd0},
    {16'h4849, 16'hABCD, 4'd5, 2'd1, 2'd0},
    {16'hC848, 16'h0000, 4'd0, 2'd0, 2'd0},
    {16'h484D, 16'h0000, 4'd0, 2'd2, 2'd0}
  };

  logic clk, rst_n, in_valid, busy, bus_req, bus_ack, bus_err;
  logic out_valid, out_subst, exc_illegal;
  logic [15:0] in_opcode, bus_rdata, out_opcode;
  logic [ADDR_W-1:0] bus_addr;
  logic [2:0] bus_fc;
  int n_run, n_fail;

  bkpt_resolver #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
    .busy(busy), .bus_req(bus_req), .bus_addr(bus_addr), .bus_fc(bus_fc),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .out_valid(out_valid), .out_opcode(out_opcode), .out_subst(out_subst),
    .exc_illegal(exc_illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [15:0] op, input logic [15:0] rd, input int w, input logic [1:0] term);
    bit hit;
    logic [ADDR_W-1:0] exp_addr;
    hit = (op >= 16'h4848) && (op <= 16'h484F);
    exp_addr = ADDR_W'(op[2:0]) << 2;
    @(negedge clk); in_valid = 1'b1; in_opcode = op;
    @(negedge clk); in_valid = 1'b0;
    if (!hit) begin
      check(out_valid == 1'b1, "R2 out_valid", 32'(out_valid), 1);
      check(out_opcode == op, "R2 out_opcode", 32'(out_opcode), 32'(op));
      check(!out_subst && !bus_req, "R2 no subst/no bus", {out_subst, bus_req}, 0);
      @(negedge clk);
      check(!out_valid && !exc_illegal, "R10 pulse end", {out_valid, exc_illegal}, 0);
    end else begin
      check(bus_req && busy, "R3/R8 request start", {bus_req, busy}, 3);
      check(bus_fc == 3'b111, "R3 fc", 32'(bus_fc), 7);
      check(bus_addr == exp_addr, "R3 addr", 32'(bus_addr), 32'(exp_addr));
      for (int i = 0; i < w; i++) begin
        @(negedge clk);
        check(bus_req && bus_addr == exp_addr && bus_fc == 3'b111, "R4 hold",
              32'(bus_addr), 32'(exp_addr));
      end
      bus_ack = term[0]; bus_err = term[1]; bus_rdata = rd;
      @(negedge clk); bus_ack = 1'b0; bus_err = 1'b0;
      check(!bus_req && !busy, "R5/R6 release", {bus_req, busy}, 0);
      if (term[1]) begin
        check(exc_illegal && !out_valid, term[0] ? "R7 err wins" : "R6 exception",
              {exc_illegal, out_valid}, 2);
      end else begin
        check(out_valid && out_subst, "R5 valid+subst", {out_valid, out_subst}, 3);
        check(out_opcode == rd, "R5 replacement", 32'(out_opcode), 32'(rd));
      end
      @(negedge clk);
      check(!out_valid && !exc_illegal, "R10 pulse end", {out_valid, exc_illegal}, 0);
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    in_valid = 0; in_opcode = '0; bus_ack = 0; bus_err = 0; bus_rdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(!bus_req && !out_valid && !exc_illegal && !busy && bus_fc == 3'b000,
          "R1 reset state", {bus_req, out_valid, exc_illegal, busy, bus_fc}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!bus_req && !out_valid && !busy, "R1 after release", {bus_req, out_valid, busy}, 0);

    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][39:24], VEC[v][23:8], int'(VEC[v][7:4]), VEC[v][3:2]);

    // R9: terminations with no request active
    @(negedge clk); bus_ack = 1; bus_err = 0; bus_rdata = 16'h5A5A;
    @(negedge clk); bus_ack = 0; bus_err = 1;
    @(negedge clk); bus_err = 0;
    check(!out_valid && !exc_illegal && !bus_req, "R9 stray ack/err",
          {out_valid, exc_illegal, bus_req}, 0);
    @(negedge clk);
    check(!out_valid && !exc_illegal && !bus_req, "R9 stray ack/err later",
          {out_valid, exc_illegal, bus_req}, 0);

    // R8: opcodes while busy are dropped
    @(negedge clk); in_valid = 1; in_opcode = 16'h484A;
    @(negedge clk); in_opcode = 16'h1234;
    @(negedge clk); in_opcode = 16'h484E;
    @(negedge clk); in_valid = 0;
    check(busy && bus_req && bus_addr == ADDR_W'(24'h8), "R8 request kept",
          32'(bus_addr), 32'h8);
    check(!out_valid, "R8 no pass-through while busy", 32'(out_valid), 0);
    bus_ack = 1; bus_rdata = 16'h7001;
    @(negedge clk); bus_ack = 0;
    check(out_valid && out_opcode == 16'h7001, "R8/R5 resolve after busy",
          32'(out_opcode), 32'h7001);
    @(negedge clk);
    check(!out_valid && !bus_req, "R8 dropped opcodes left no trace",
          {out_valid, bus_req}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule